// File: doc/BRIEF.md
# External Bus Mastership Handover Controller

This block decides when a shared external memory bus passes from the on-chip memory controller to an outside bus master, and when it comes back. The outside master raises a request. The block brings that request into the local clock domain, lets any running local memory cycle end or reach a safe point, and then raises an acknowledge. While the acknowledge is high, the block turns off the output enables of the local pin groups, so the outside master can drive the memory itself.

A grant that lands on a synchronous DRAM write would otherwise leave the SDRAM write controls floating. Such a stray write could corrupt memory. To prevent it, the block forces the SDRAM chip select inactive in the same cycle the acknowledge rises. It then keeps address and data driven for one or two more bus clocks, chosen by an input, before it lets them float.

Local DRAM refresh is held off for as long as the bus is given away. A refresh request that arrives in that time is kept as pending and is issued first once the bus is back. The memory controller watches a hold output, and it starts no new cycle while that output is high.

Top module: `bus_handover_ctrl`

## Requirements
- R1: The request passes through a synchronizer of SYNC_STAGES flops (default 2). With the defaults, `ext_acq` can first be high after the third rising clock edge that samples `ext_req` high.
- R2: The acknowledge rises only if the synchronized request was high in the cycle before. A request withdrawn while the block waits for a cycle to end returns the block to idle with no acknowledge.
- R3: While `cyc_busy` is high and `cyc_sdram_wr` is low, no grant is given. The acknowledge rises one clock after `cyc_busy` falls.
- R4: In the full-grant phase, `oe_addr`, `oe_data` and `oe_ctrl` are all 0.
- R5: A grant made while `cyc_sdram_wr` is high raises `sd_cs_off` in the same cycle as `ext_acq`. `oe_addr` and `oe_data` stay 1 for 1 cycle (`rel_two`=0) or 2 cycles (`rel_two`=1) of acknowledge, then fall to 0. `oe_ctrl` is 0 from the first acknowledge cycle.
- R6: A grant made without an SDRAM write drops all three output enables in the cycle the acknowledge rises.
- R7: The acknowledge falls one clock after the synchronized request falls. The output enables return to 1 one clock after that.
- R8: `sd_cs_off` stays 1 after the bus is reclaimed, until `sd_cmd_new` is seen high while the block is idle. It falls on the next clock.
- R9: `rfsh_go` is never high while `mc_hold` is high.
- R10: A refresh requested during a grant is issued (`rfsh_go`=1) in the first idle cycle after reclaim. A request still pending at that point is granted no earlier than the cycle after the refresh issue.
- R11: `mc_hold` is 1 in every state except idle. The controller state is one-hot.
- R12: After reset: `ext_acq`=0, `mc_hold`=0, all output enables 1, `sd_cs_off`=0, `rfsh_go`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_req | input | 1 | Asynchronous request from the outside master |
| cyc_busy | input | 1 | A local memory cycle is in progress |
| cyc_sdram_wr | input | 1 | The current local cycle is an SDRAM write |
| rel_two | input | 1 | 0: hold address/data 1 clock after grant; 1: hold 2 clocks |
| sd_cmd_new | input | 1 | Controller issues a fresh SDRAM command |
| rfsh_req | input | 1 | Refresh timer pulse |
| ext_acq | output | 1 | Acknowledge to the outside master |
| mc_hold | output | 1 | Controller must not start new cycles |
| oe_addr | output | 1 | Output enable, address pins |
| oe_data | output | 1 | Output enable, data pins |
| oe_ctrl | output | 1 | Output enable, strobes, ROM select, RAS and CAS |
| sd_cs_off | output | 1 | Force SDRAM chip select inactive (high) |
| rfsh_go | output | 1 | Issue a local refresh now |

## Verification
Two events can fall in the same cycle: a refresh timer pulse landing inside a grant, and the outside master asking for the bus again just as it is reclaimed. The bench drops the request and raises it again one clock later, with a refresh already pending. When the block reaches idle, it must issue the refresh first and hold the acknowledge low for that cycle. A cycle-accurate model in the bench judges this, together with the release timing for one- and two-clock hold-off.

// File: rtl/bho_pkg.sv
package bho_pkg;
   localparam int ST_W    = 6;
   localparam int S_IDLE  = 0;
   localparam int S_WAIT  = 1;
   localparam int S_CSOFF = 2;
   localparam int S_RDLY  = 3;
   localparam int S_GRANT = 4;
   localparam int S_RECL  = 5;
   typedef logic [ST_W-1:0] bho_state_t;
endpackage

// File: rtl/bho_sync.sv
module bho_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad
         $error("bho_sync needs at least two stages");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/bho_fsm.sv
module bho_fsm
   import bho_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_s,
   input  logic       cyc_busy,
   input  logic       cyc_sdram_wr,
   input  logic       rel_two,
   input  logic       sd_cmd_new,
   input  logic       rfsh_pend,
   output bho_state_t st,
   output logic       ext_acq,
   output logic       oe_addr,
   output logic       oe_data,
   output logic       oe_ctrl,
   output logic       cs_off
);
   bho_state_t nxt;
   logic       nxt_acq;

   always_comb begin
      nxt = '0;
      unique case (1'b1)
         st[S_IDLE]: begin
            if (req_s && !rfsh_pend) begin
               if (cyc_sdram_wr)  nxt[S_CSOFF] = 1'b1;
               else if (cyc_busy) nxt[S_WAIT]  = 1'b1;
               else               nxt[S_GRANT] = 1'b1;
            end else begin
               nxt[S_IDLE] = 1'b1;
            end
         end
         st[S_WAIT]: begin
            if (!req_s)            nxt[S_IDLE]  = 1'b1;
            else if (cyc_sdram_wr) nxt[S_CSOFF] = 1'b1;
            else if (!cyc_busy)    nxt[S_GRANT] = 1'b1;
            else                   nxt[S_WAIT]  = 1'b1;
         end
         st[S_CSOFF]: begin
            if (!req_s)       nxt[S_RECL]  = 1'b1;
            else if (rel_two) nxt[S_RDLY]  = 1'b1;
            else              nxt[S_GRANT] = 1'b1;
         end
         st[S_RDLY]: begin
            if (!req_s) nxt[S_RECL]  = 1'b1;
            else        nxt[S_GRANT] = 1'b1;
         end
         st[S_GRANT]: begin
            if (!req_s) nxt[S_RECL]  = 1'b1;
            else        nxt[S_GRANT] = 1'b1;
         end
         default: nxt[S_IDLE] = 1'b1;
      endcase
   end

   assign nxt_acq = nxt[S_CSOFF] | nxt[S_RDLY] | nxt[S_GRANT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= '0;
         st[S_IDLE] <= 1'b1;
         cs_off <= 1'b0;
      end else begin
         st <= nxt;
         if (nxt_acq)                       cs_off <= 1'b1;
         else if (st[S_IDLE] && sd_cmd_new) cs_off <= 1'b0;
      end
   end

   assign ext_acq = st[S_CSOFF] | st[S_RDLY] | st[S_GRANT];
   assign oe_addr = st[S_IDLE] | st[S_WAIT] | st[S_CSOFF] | st[S_RDLY];
   assign oe_data = oe_addr;
   assign oe_ctrl = st[S_IDLE] | st[S_WAIT];

   assert_state_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(st) == 1);
   assert_acq_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ext_acq) |-> $past(req_s));
   assert_acq_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_acq && !req_s) |=> !ext_acq);
   assert_cs_with_acq_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ext_acq |-> cs_off);
   assert_ctrl_float_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ext_acq |-> !oe_ctrl);
   assert_groups_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_acq && !oe_addr) |-> (!oe_data && !oe_ctrl));
endmodule

// File: rtl/bho_rfsh.sv
module bho_rfsh (
   input  logic clk,
   input  logic rst_n,
   input  logic rfsh_req,
   input  logic bus_idle,
   input  logic cyc_busy,
   output logic rfsh_go,
   output logic rfsh_pend
);
   assign rfsh_go = rfsh_pend & bus_idle & ~cyc_busy;

   always_ff @(posedge clk) begin
      if (!rst_n) rfsh_pend <= 1'b0;
      else        rfsh_pend <= rfsh_req | (rfsh_pend & ~rfsh_go);
   end

   assert_no_rfsh_granted_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_idle |-> !rfsh_go);
endmodule

// File: rtl/bus_handover_ctrl.sv
module bus_handover_ctrl
   import bho_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ext_req,
   input  logic cyc_busy,
   input  logic cyc_sdram_wr,
   input  logic rel_two,
   input  logic sd_cmd_new,
   input  logic rfsh_req,
   output logic ext_acq,
   output logic mc_hold,
   output logic oe_addr,
   output logic oe_data,
   output logic oe_ctrl,
   output logic sd_cs_off,
   output logic rfsh_go
);
   logic       req_s;
   logic       pend;
   bho_state_t st;

   bho_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(ext_req), .q(req_s)
   );

   bho_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .req_s(req_s), .cyc_busy(cyc_busy),
      .cyc_sdram_wr(cyc_sdram_wr), .rel_two(rel_two), .sd_cmd_new(sd_cmd_new),
      .rfsh_pend(pend), .st(st), .ext_acq(ext_acq), .oe_addr(oe_addr),
      .oe_data(oe_data), .oe_ctrl(oe_ctrl), .cs_off(sd_cs_off)
   );

   bho_rfsh u_rfsh (
      .clk(clk), .rst_n(rst_n), .rfsh_req(rfsh_req), .bus_idle(st[S_IDLE]),
      .cyc_busy(cyc_busy), .rfsh_go(rfsh_go), .rfsh_pend(pend)
   );

   assign mc_hold = ~st[S_IDLE];

   assert_hold_blocks_rfsh_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mc_hold |-> !rfsh_go);
endmodule

// File: tb/bus_handover_ctrl_test.sv
`timescale 1ns/100ps
module bus_handover_ctrl_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ext_req = 0, cyc_busy = 0, cyc_sdram_wr = 0, rel_two = 0;
   logic sd_cmd_new = 0, rfsh_req = 0;
   logic ext_acq, mc_hold, oe_addr, oe_data, oe_ctrl, sd_cs_off, rfsh_go;
   int checks = 0, errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   bus_handover_ctrl uut (
      .clk(clk), .rst_n(rst_n), .ext_req(ext_req), .cyc_busy(cyc_busy),
      .cyc_sdram_wr(cyc_sdram_wr), .rel_two(rel_two), .sd_cmd_new(sd_cmd_new),
      .rfsh_req(rfsh_req), .ext_acq(ext_acq), .mc_hold(mc_hold),
      .oe_addr(oe_addr), .oe_data(oe_data), .oe_ctrl(oe_ctrl),
      .sd_cs_off(sd_cs_off), .rfsh_go(rfsh_go)
   );

   // behavioural reference: phase 0 idle,1 wait,2 cs-off,3 delay,4 granted,5 reclaim
   bit m_s1, m_s2, m_hold, m_pend;
   int m_ph;

   always @(posedge clk) begin
      bit go;
      int np;
      if (!rst_n) begin
         m_s1 = 0; m_s2 = 0; m_hold = 0; m_pend = 0; m_ph = 0;
      end else begin
         go = m_pend && m_ph == 0 && !cyc_busy;
         np = m_ph;
         if (m_ph == 0) begin
            if (m_s2 && !m_pend) np = cyc_sdram_wr ? 2 : (cyc_busy ? 1 : 4);
         end else if (m_ph == 1) begin
            if (!m_s2) np = 0;
            else if (cyc_sdram_wr) np = 2;
            else if (!cyc_busy) np = 4;
         end else if (m_ph == 2) np = !m_s2 ? 5 : (rel_two ? 3 : 4);
         else if (m_ph == 3) np = !m_s2 ? 5 : 4;
         else if (m_ph == 4) np = !m_s2 ? 5 : 4;
         else np = 0;
         if (np >= 2 && np <= 4) m_hold = 1;
         else if (m_ph == 0 && sd_cmd_new) m_hold = 0;
         m_pend = rfsh_req || (m_pend && !go);
         m_s2 = m_s1; m_s1 = ext_req; m_ph = np;
      end
   end

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always begin
      @(posedge clk); #2;
      if (rst_n && !done) begin
         chk("R2 acq", ext_acq, (m_ph >= 2 && m_ph <= 4));
         chk("R4 oe_addr", oe_addr, (m_ph <= 3));
         chk("R4 oe_data", oe_data, (m_ph <= 3));
         chk("R4 oe_ctrl", oe_ctrl, (m_ph <= 1));
         chk("R8 cs_off", sd_cs_off, m_hold);
         chk("R10 rfsh_go", rfsh_go, (m_pend && m_ph == 0 && !cyc_busy));
         chk("R11 hold", mc_hold, (m_ph != 0));
      end
   end

   task automatic tick(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
      end
   endtask

   task automatic give_back();
      ext_req = 0; cyc_busy = 0; cyc_sdram_wr = 0;
      tick(4);
      sd_cmd_new = 1; tick(1); sd_cmd_new = 0; tick(1);
   endtask

   initial begin
      tick(3);
      chk("R12 acq", ext_acq, 0); chk("R12 oe_addr", oe_addr, 1);
      chk("R12 oe_ctrl", oe_ctrl, 1); chk("R12 cs", sd_cs_off, 0);
      chk("R12 go", rfsh_go, 0); chk("R12 hold", mc_hold, 0);
      rst_n = 1; tick(1);

      // plain grant, no local cycle
      ext_req = 1;
      tick(2); chk("R1 early", ext_acq, 0);
      tick(1); chk("R1 third edge", ext_acq, 1);
      chk("R6 addr", oe_addr, 0); chk("R6 ctrl", oe_ctrl, 0);
      tick(2); chk("R4 data", oe_data, 0);
      ext_req = 0;
      tick(2); chk("R7 still", ext_acq, 1);
      tick(1); chk("R7 drop", ext_acq, 0); chk("R7 oe late", oe_addr, 0);
      tick(1); chk("R7 oe back", oe_addr, 1); chk("R7 ctrl back", oe_ctrl, 1);
      chk("R8 hold cs", sd_cs_off, 1);
      tick(2); chk("R8 still", sd_cs_off, 1);
      sd_cmd_new = 1; tick(1); sd_cmd_new = 0;
      chk("R8 freed", sd_cs_off, 0);

      // busy non-SDRAM cycle must finish
      cyc_busy = 1; ext_req = 1;
      tick(3); chk("R11 wait hold", mc_hold, 1); chk("R3 wait", ext_acq, 0);
      tick(3); chk("R3 still", ext_acq, 0);
      cyc_busy = 0; tick(1); chk("R3 after end", ext_acq, 1);
      give_back();

      // SDRAM write, one-clock hold-off
      cyc_sdram_wr = 1; cyc_busy = 1; rel_two = 0; ext_req = 1;
      tick(3); chk("R5 acq", ext_acq, 1); chk("R5 cs", sd_cs_off, 1);
      chk("R5 addr kept", oe_addr, 1); chk("R5 data kept", oe_data, 1);
      chk("R5 ctrl off", oe_ctrl, 0);
      cyc_sdram_wr = 0; cyc_busy = 0;
      tick(1); chk("R5 addr off 1", oe_addr, 0);
      give_back();

      // SDRAM write, two-clock hold-off
      cyc_sdram_wr = 1; cyc_busy = 1; rel_two = 1; ext_req = 1;
      tick(3); chk("R5 acq2", ext_acq, 1); chk("R5 addr c1", oe_addr, 1);
      cyc_sdram_wr = 0; cyc_busy = 0;
      tick(1); chk("R5 addr c2", oe_addr, 1);
      tick(1); chk("R5 addr off 2", oe_addr, 0); chk("R5 data off 2", oe_data, 0);
      give_back(); rel_two = 0;

      // request withdrawn while waiting
      cyc_busy = 1; ext_req = 1;
      tick(3); chk("R2 waiting", mc_hold, 1);
      ext_req = 0;
      for (int i = 0; i < 4; i++) begin tick(1); chk("R2 no acq", ext_acq, 0); end
      chk("R2 back idle", mc_hold, 0);
      cyc_busy = 0; tick(1); chk("R2 no late acq", ext_acq, 0);

      // refresh during grant, re-request at reclaim
      ext_req = 1; tick(3); chk("R10 granted", ext_acq, 1);
      rfsh_req = 1; tick(1); rfsh_req = 0;
      chk("R9 no go", rfsh_go, 0);
      tick(2); chk("R9 still", rfsh_go, 0);
      ext_req = 0; tick(1); ext_req = 1;
      tick(2); chk("R9 reclaim", rfsh_go, 0); chk("R7 reclaim acq", ext_acq, 0);
      tick(1); chk("R10 go first", rfsh_go, 1); chk("R10 defer", ext_acq, 0);
      tick(1); chk("R10 go once", rfsh_go, 0); chk("R10 still idle", ext_acq, 0);
      tick(1); chk("R10 regrant", ext_acq, 1);
      give_back();

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule